// File: doc/BRIEF.md
# Command-Byte Register Interface Controller

This block is the control plane of a keypad-scanner and GPIO peripheral. It sits behind a serial target interface whose bit-level framing has already been decoded, and sees only three kinds of event: a transaction start carrying a direction, a written byte, and a request for one read byte. The first byte written after a start selects a command. Every later written byte is a parameter, indexed by a byte counter that restarts with each transaction. Read requests return one byte each, chosen by the latched command and the same counter.

The block holds the configuration, active-time, debounce, keypad-size and clock settings, three 16-bit GPIO registers (pull, direction, state), an interrupt status byte and a sticky error byte. Every write command checks its parameter. A rejected value is still stored where the command stores values, but it also raises an error flag and the interrupt. The active-low interrupt line is low whenever any status bit is set. The key FIFO lives in the scanner, so a configuration write asks for the FIFO to be emptied through a one-cycle flush pulse.

Top module: `kpc_regif`

## Requirements
- R1: After reset: configuration 0x80, status 0x10 (only the not-initialised bit 4), active time 125, debounce 3, keypad size 0x33, clock 0x08, GPIO registers 0, error flags 0, read byte 0, no command latched.
- R2: `irq_n_o` is low exactly while the status byte is nonzero. A key event sets status bit 0. `pwm_end_i[n]` sets status bit 5+n. A set that arrives in the same cycle as a status clear survives the clear.
- R3: A read under command 0x82 returns the status byte and then clears it, except while bit 4 is set, in which case the status is left unchanged.
- R4: Command 0x83 with parameter 0xAA restores every register, the status and the error flags to their R1 values. Any other parameter sets the bad-parameter error.
- R5: A parameter to command 0x81 stores the configuration, clears the status, drives `fifo_flush_o` high for the one following cycle and unlatches the command. A read under 0x92 returns the configuration's low 4 bits, with the upper 4 bits as 0.
- R6: Commands 0x84 (pull), 0x85 (direction) and 0x86 (state) take the low byte first, which is stored zero-extended. The high byte comes next and unlatches the command. Reads under 0x87 (direction) and 0x88 (state) return the low byte, then the high byte, then 0.
- R7: Command 0x90 stores the keypad size and sets bad-parameter when the low nibble is outside 3..12 or the high nibble is outside 3..8. A read under 0x91 returns the stored byte.
- R8: Command 0x8F stores the debounce time and sets bad-parameter when the value is 0. Command 0x8B stores the active time with no check.
- R9: Command 0x93 stores the clock byte and sets bad-parameter when its low two bits are 01 or 10. A read under 0x94 returns the stored byte with its low two bits replaced by 10.
- R10: Under command 0x80, read byte 0 returns 0x00, read byte 1 returns 0x04, and later bytes return 0.
- R11: The unknown-command error (error bit 1) is set by a parameter byte under a code that is not a write command (the code stays latched), and by a read with no command latched or under a code that is not a read command. Such a read returns 0.
- R12: Setting any error bit also sets status bit 3. The error byte (bad-parameter bit 0, unknown-command bit 1) is read under 0x8C, and its bits stay set until a reset.
- R13: A parameter byte that arrives with no command latched sets bad-parameter. A start event resets the byte index to 0.
- R14: Read data appears on `rd_byte_o` one cycle after the request and holds until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start_i | input | 1 | Start of a transaction (one-cycle pulse) |
| txn_write_i | input | 1 | Direction of the transaction that is starting (1 = write) |
| wr_valid_i | input | 1 | A written byte is present |
| wr_byte_i | input | 8 | Written byte |
| rd_req_i | input | 1 | Request for one read byte |
| rd_byte_o | output | 8 | Returned read byte |
| irq_n_o | output | 1 | Active-low interrupt |
| key_event_i | input | 1 | The scanner queued a key event |
| pwm_end_i | input | 3 | End-of-script pulse per PWM channel |
| fifo_flush_o | output | 1 | Request to empty the scanner's key FIFO |
| cfg_o | output | 8 | Configuration byte |
| active_time_o | output | 8 | Active time |
| debounce_o | output | 8 | Debounce time |
| key_size_o | output | 8 | Keypad size, rows in the low nibble and columns in the high nibble |
| clk_cfg_o | output | 8 | Clock configuration |
| gpio_pull_o | output | 16 | GPIO pull select |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_state_o | output | 16 | GPIO state |

## Verification
A status read can clear the status byte in the same cycle that a key event, a PWM end pulse or an error tries to set a bit in it. A configuration write's clear can meet a key event in the same way. The bench raises `key_event_i` and `pwm_end_i` in the very cycle of a 0x82 read request and of the 0x81 parameter byte. It then judges the outcome from `irq_n_o` and from a second status read, both of which must still show the newly set bit. A behavioural model, compared on every clock, scores the same collisions.

// File: rtl/kpc_pkg.sv
package kpc_pkg;

  localparam logic [7:0] CMD_ID       = 8'h80;
  localparam logic [7:0] CMD_CFG_WR   = 8'h81;
  localparam logic [7:0] CMD_STAT_RD  = 8'h82;
  localparam logic [7:0] CMD_SRST     = 8'h83;
  localparam logic [7:0] CMD_PULL_WR  = 8'h84;
  localparam logic [7:0] CMD_DIR_WR   = 8'h85;
  localparam logic [7:0] CMD_STATE_WR = 8'h86;
  localparam logic [7:0] CMD_DIR_RD   = 8'h87;
  localparam logic [7:0] CMD_STATE_RD = 8'h88;
  localparam logic [7:0] CMD_ACT_WR   = 8'h8B;
  localparam logic [7:0] CMD_ERR_RD   = 8'h8C;
  localparam logic [7:0] CMD_DEB_WR   = 8'h8F;
  localparam logic [7:0] CMD_SIZE_WR  = 8'h90;
  localparam logic [7:0] CMD_SIZE_RD  = 8'h91;
  localparam logic [7:0] CMD_CFG_RD   = 8'h92;
  localparam logic [7:0] CMD_CLK_WR   = 8'h93;
  localparam logic [7:0] CMD_CLK_RD   = 8'h94;

  localparam logic [7:0] SRST_KEY = 8'hAA;

  localparam int PWM_CH    = 3;
  localparam int ST_KEY    = 0;
  localparam int ST_ERR    = 3;
  localparam int ST_NOINIT = 4;
  localparam int ST_PWM0   = 5;
  localparam int ER_BADPAR = 0;
  localparam int ER_UNKCMD = 1;

  localparam logic [7:0] RST_CFG    = 8'h80;
  localparam logic [7:0] RST_STATUS = 8'h10;
  localparam logic [7:0] RST_ACT    = 8'd125;
  localparam logic [7:0] RST_DEB    = 8'd3;
  localparam logic [7:0] RST_SIZE   = 8'h33;
  localparam logic [7:0] RST_CLK    = 8'h08;

  typedef struct packed {
    logic       cfg;
    logic       srst;
    logic       act;
    logic       deb;
    logic       size;
    logic       clkc;
    logic [2:0] gpio;
    logic       done;
    logic       badpar;
    logic       unkcmd;
  } wr_fx_t;

  function automatic logic size_ok(input logic [7:0] v, input int lo_min,
                                   input int lo_max, input int hi_min, input int hi_max);
    int lo;
    int hi;
    lo = int'(v[3:0]);
    hi = int'(v[7:4]);
    return (lo >= lo_min) && (lo <= lo_max) && (hi >= hi_min) && (hi <= hi_max);
  endfunction

  function automatic logic clk_ok(input logic [7:0] v);
    return (v[1:0] == 2'b00) || (v[1:0] == 2'b11);
  endfunction

  function automatic logic [7:0] clk_view(input logic [7:0] v);
    return {v[7:2], 2'b10};
  endfunction

  function automatic logic [7:0] cfg_view(input logic [7:0] v);
    return {4'h0, v[3:0]};
  endfunction

endpackage

// File: rtl/kpc_txn_track.sv
module kpc_txn_track #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             rd_req_i,
  input  logic             release_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pidx_o,
  output logic [7:0]       cmd_o,
  output logic             cmd_valid_o,
  output logic             param_stb_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       cmd_q;
  logic             cmd_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      cmd_q       <= '0;
      cmd_valid_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else begin
      if ((wr_valid_i || rd_req_i) && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + CNT_W'(1);
      if (wr_valid_i && (cnt_q == '0)) begin
        cmd_q       <= wr_byte_i;
        cmd_valid_q <= 1'b1;
      end else if (release_i) begin
        cmd_valid_q <= 1'b0;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign pidx_o      = cnt_q - CNT_W'(1);
  assign cmd_o       = cmd_q;
  assign cmd_valid_o = cmd_valid_q;
  assign param_stb_o = wr_valid_i && !start_i && (cnt_q != '0);

endmodule

// File: rtl/kpc_cmd_decode.sv
module kpc_cmd_decode
  import kpc_pkg::*;
#(
  parameter int GPIO_BYTES = 2,
  parameter int CNT_W      = 3,
  parameter int ROW_MIN    = 3,
  parameter int ROW_MAX    = 12,
  parameter int COL_MIN    = 3,
  parameter int COL_MAX    = 8
) (
  input  logic             param_stb_i,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_i,
  input  logic [CNT_W-1:0] pidx_i,
  input  logic [7:0]       wr_byte_i,
  output wr_fx_t           fx_o
);

  localparam logic [CNT_W-1:0] LAST_GPIO = CNT_W'(GPIO_BYTES - 1);

  always_comb begin
    fx_o = '0;
    if (param_stb_i) begin
      if (!cmd_valid_i) begin
        fx_o.badpar = 1'b1;
      end else begin
        case (cmd_i)
          CMD_CFG_WR: begin
            fx_o.cfg  = 1'b1;
            fx_o.done = 1'b1;
          end
          CMD_SRST: begin
            fx_o.done   = 1'b1;
            fx_o.srst   = (wr_byte_i == SRST_KEY);
            fx_o.badpar = (wr_byte_i != SRST_KEY);
          end
          CMD_PULL_WR, CMD_DIR_WR, CMD_STATE_WR: begin
            fx_o.gpio = 3'b001 << cmd_i[1:0];
            fx_o.done = (pidx_i == LAST_GPIO);
          end
          CMD_ACT_WR: begin
            fx_o.act  = 1'b1;
            fx_o.done = 1'b1;
          end
          CMD_DEB_WR: begin
            fx_o.deb    = 1'b1;
            fx_o.done   = 1'b1;
            fx_o.badpar = (wr_byte_i == 8'h00);
          end
          CMD_SIZE_WR: begin
            fx_o.size   = 1'b1;
            fx_o.done   = 1'b1;
            fx_o.badpar = !size_ok(wr_byte_i, ROW_MIN, ROW_MAX, COL_MIN, COL_MAX);
          end
          CMD_CLK_WR: begin
            fx_o.clkc   = 1'b1;
            fx_o.done   = 1'b1;
            fx_o.badpar = !clk_ok(wr_byte_i);
          end
          default: fx_o.unkcmd = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/kpc_regfile.sv
module kpc_regfile
  import kpc_pkg::*;
#(
  parameter int          GPIO_BYTES = 2,
  parameter int          CNT_W      = 3,
  parameter logic [15:0] CHIP_ID    = 16'h0400,
  localparam int         GPIO_W     = 8 * GPIO_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic              srst_i,
  input  logic              act_we_i,
  input  logic              deb_we_i,
  input  logic              size_we_i,
  input  logic              clk_we_i,
  input  logic [2:0]        gpio_we_i,
  input  logic              badpar_i,
  input  logic              unkcmd_i,
  input  logic [CNT_W-1:0]  pidx_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              rd_req_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_i,
  input  logic [CNT_W-1:0]  ridx_i,
  input  logic              key_event_i,
  input  logic [PWM_CH-1:0] pwm_end_i,
  output logic [7:0]        cfg_o,
  output logic [7:0]        act_o,
  output logic [7:0]        deb_o,
  output logic [7:0]        size_o,
  output logic [7:0]        clkc_o,
  output logic [GPIO_W-1:0] gpio_pull_o,
  output logic [GPIO_W-1:0] gpio_dir_o,
  output logic [GPIO_W-1:0] gpio_state_o,
  output logic [7:0]        status_o,
  output logic [7:0]        err_o,
  output logic [7:0]        rd_byte_o,
  output logic              flush_o,
  output logic              err_evt_o,
  output logic              rd_stat_evt_o
);

  logic [7:0]        cfg_q, act_q, deb_q, size_q, clkc_q, status_q, err_q, rd_q;
  logic              flush_q;
  logic [GPIO_W-1:0] gpio_q [3];
  logic [7:0]        rd_val;
  logic              rd_unk;
  logic              unk_any;
  logic [7:0]        err_new;
  logic [7:0]        st_set;
  logic              st_clr;

  function automatic logic [7:0] gpio_byte(input logic [GPIO_W-1:0] v,
                                           input logic [CNT_W-1:0] idx);
    if (int'(idx) < GPIO_BYTES) return v[{idx, 3'b000} +: 8];
    return 8'h00;
  endfunction

  always_comb begin
    rd_val = 8'h00;
    rd_unk = 1'b0;
    if (!cmd_valid_i) begin
      rd_unk = 1'b1;
    end else begin
      case (cmd_i)
        CMD_ID:       rd_val = (ridx_i < CNT_W'(2)) ? CHIP_ID[{ridx_i[0], 3'b000} +: 8] : 8'h00;
        CMD_STAT_RD:  rd_val = status_q;
        CMD_DIR_RD:   rd_val = gpio_byte(gpio_q[1], ridx_i);
        CMD_STATE_RD: rd_val = gpio_byte(gpio_q[2], ridx_i);
        CMD_ERR_RD:   rd_val = err_q;
        CMD_SIZE_RD:  rd_val = size_q;
        CMD_CFG_RD:   rd_val = cfg_view(cfg_q);
        CMD_CLK_RD:   rd_val = clk_view(clkc_q);
        default:      rd_unk = 1'b1;
      endcase
    end
  end

  assign unk_any       = unkcmd_i || (rd_req_i && rd_unk);
  assign err_evt_o     = badpar_i || unk_any;
  assign rd_stat_evt_o = rd_req_i && cmd_valid_i && (cmd_i == CMD_STAT_RD);
  assign st_clr        = cfg_we_i || (rd_stat_evt_o && !status_q[ST_NOINIT]);

  always_comb begin
    err_new            = 8'h00;
    err_new[ER_BADPAR] = badpar_i;
    err_new[ER_UNKCMD] = unk_any;
    st_set             = 8'h00;
    st_set[ST_KEY]     = key_event_i;
    st_set[ST_ERR]     = err_evt_o;
    st_set[ST_PWM0 +: PWM_CH] = pwm_end_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= RST_CFG;
      act_q    <= RST_ACT;
      deb_q    <= RST_DEB;
      size_q   <= RST_SIZE;
      clkc_q   <= RST_CLK;
      status_q <= RST_STATUS;
      err_q    <= 8'h00;
      rd_q     <= 8'h00;
      flush_q  <= 1'b0;
      for (int g = 0; g < 3; g++) gpio_q[g] <= '0;
    end else begin
      flush_q <= cfg_we_i;
      if (rd_req_i) rd_q <= rd_val;
      if (srst_i) begin
        cfg_q    <= RST_CFG;
        act_q    <= RST_ACT;
        deb_q    <= RST_DEB;
        size_q   <= RST_SIZE;
        clkc_q   <= RST_CLK;
        status_q <= RST_STATUS;
        err_q    <= 8'h00;
        for (int g = 0; g < 3; g++) gpio_q[g] <= '0;
      end else begin
        if (cfg_we_i)  cfg_q  <= wr_byte_i;
        if (act_we_i)  act_q  <= wr_byte_i;
        if (deb_we_i)  deb_q  <= wr_byte_i;
        if (size_we_i) size_q <= wr_byte_i;
        if (clk_we_i)  clkc_q <= wr_byte_i;
        for (int g = 0; g < 3; g++) begin
          if (gpio_we_i[g]) begin
            if (pidx_i == '0) gpio_q[g] <= GPIO_W'(wr_byte_i);
            else              gpio_q[g][{pidx_i, 3'b000} +: 8] <= wr_byte_i;
          end
        end
        err_q    <= err_q | err_new;
        status_q <= (st_clr ? 8'h00 : status_q) | st_set;
      end
    end
  end

  assign cfg_o        = cfg_q;
  assign act_o        = act_q;
  assign deb_o        = deb_q;
  assign size_o       = size_q;
  assign clkc_o       = clkc_q;
  assign gpio_pull_o  = gpio_q[0];
  assign gpio_dir_o   = gpio_q[1];
  assign gpio_state_o = gpio_q[2];
  assign status_o     = status_q;
  assign err_o        = err_q;
  assign rd_byte_o    = rd_q;
  assign flush_o      = flush_q;

endmodule

// File: rtl/kpc_regif.sv
module kpc_regif
  import kpc_pkg::*;
#(
  parameter int          GPIO_BYTES = 2,
  parameter int          ROW_MIN    = 3,
  parameter int          ROW_MAX    = 12,
  parameter int          COL_MIN    = 3,
  parameter int          COL_MAX    = 8,
  parameter logic [15:0] CHIP_ID    = 16'h0400,
  localparam int         GPIO_W     = 8 * GPIO_BYTES,
  localparam int         CNT_W      = $clog2(GPIO_BYTES + 2) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start_i,
  input  logic              txn_write_i,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              rd_req_i,
  output logic [7:0]        rd_byte_o,
  output logic              irq_n_o,
  input  logic              key_event_i,
  input  logic [2:0]        pwm_end_i,
  output logic              fifo_flush_o,
  output logic [7:0]        cfg_o,
  output logic [7:0]        active_time_o,
  output logic [7:0]        debounce_o,
  output logic [7:0]        key_size_o,
  output logic [7:0]        clk_cfg_o,
  output logic [GPIO_W-1:0] gpio_pull_o,
  output logic [GPIO_W-1:0] gpio_dir_o,
  output logic [GPIO_W-1:0] gpio_state_o
);

  logic [CNT_W-1:0] cnt, pidx;
  logic [7:0]       cmd;
  logic             cmd_valid;
  logic             param_stb;
  wr_fx_t           fx;
  logic [7:0]       status_q, err_q;
  logic             err_evt, rd_stat_evt;
  logic             cfg_evt, srst_evt;
  logic             wr_dir_unused;

  assign wr_dir_unused = txn_write_i;
  assign cfg_evt  = fx.cfg;
  assign srst_evt = fx.srst;

  kpc_txn_track #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .start_i(txn_start_i), .wr_valid_i(wr_valid_i),
    .wr_byte_i(wr_byte_i), .rd_req_i(rd_req_i), .release_i(fx.done),
    .cnt_o(cnt), .pidx_o(pidx), .cmd_o(cmd), .cmd_valid_o(cmd_valid),
    .param_stb_o(param_stb)
  );

  kpc_cmd_decode #(
    .GPIO_BYTES(GPIO_BYTES), .CNT_W(CNT_W), .ROW_MIN(ROW_MIN), .ROW_MAX(ROW_MAX),
    .COL_MIN(COL_MIN), .COL_MAX(COL_MAX)
  ) u_dec (
    .param_stb_i(param_stb), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .pidx_i(pidx),
    .wr_byte_i(wr_byte_i), .fx_o(fx)
  );

  kpc_regfile #(.GPIO_BYTES(GPIO_BYTES), .CNT_W(CNT_W), .CHIP_ID(CHIP_ID)) u_rf (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(fx.cfg), .srst_i(fx.srst), .act_we_i(fx.act),
    .deb_we_i(fx.deb), .size_we_i(fx.size), .clk_we_i(fx.clkc), .gpio_we_i(fx.gpio),
    .badpar_i(fx.badpar), .unkcmd_i(fx.unkcmd), .pidx_i(pidx), .wr_byte_i(wr_byte_i),
    .rd_req_i(rd_req_i && !txn_start_i), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .ridx_i(cnt), .key_event_i(key_event_i), .pwm_end_i(pwm_end_i),
    .cfg_o(cfg_o), .act_o(active_time_o), .deb_o(debounce_o), .size_o(key_size_o),
    .clkc_o(clk_cfg_o), .gpio_pull_o(gpio_pull_o), .gpio_dir_o(gpio_dir_o),
    .gpio_state_o(gpio_state_o), .status_o(status_q), .err_o(err_q),
    .rd_byte_o(rd_byte_o), .flush_o(fifo_flush_o), .err_evt_o(err_evt),
    .rd_stat_evt_o(rd_stat_evt)
  );

  assign irq_n_o = ~|status_q;

endmodule

// File: rtl/kpc_regif_chk.sv
module kpc_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       err_evt,
  input logic       srst_evt,
  input logic       cfg_evt,
  input logic       rd_stat_evt,
  input logic       key_event_i,
  input logic       irq_n_o,
  input logic       fifo_flush_o,
  input logic       cmd_valid,
  input logic [7:0] status_q,
  input logic [7:0] err_q
);

  // R12
  err_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !srst_evt) |=> (!irq_n_o && status_q[3]));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_evt |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R2
  key_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_event_i && !srst_evt) |=> (status_q[0] && !irq_n_o));

  // R5
  cfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt |=> (fifo_flush_o && !cmd_valid));

  // R3
  noinit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_evt && status_q[4]) |=> status_q[4]);

  // R4
  srst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_evt |=> ((status_q == 8'h10) && (err_q == 8'h00) && !cmd_valid));

endmodule

bind kpc_regif kpc_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .srst_evt(srst_evt), .cfg_evt(cfg_evt),
  .rd_stat_evt(rd_stat_evt), .key_event_i(key_event_i), .irq_n_o(irq_n_o),
  .fifo_flush_o(fifo_flush_o), .cmd_valid(cmd_valid), .status_q(status_q), .err_q(err_q)
);

// File: tb/tb_kpc_regif.sv
`timescale 1ns/1ps
module tb_kpc_regif;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_start = 1'b0, txn_write = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic        key_event = 1'b0;
  logic [2:0]  pwm_end = 3'b000;
  logic [7:0]  rd_byte_o, cfg_o, active_time_o, debounce_o, key_size_o, clk_cfg_o;
  logic        irq_n_o, fifo_flush_o;
  logic [15:0] gpio_pull_o, gpio_dir_o, gpio_state_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  kpc_regif dut (
    .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start), .txn_write_i(txn_write),
    .wr_valid_i(wr_valid), .wr_byte_i(wr_byte), .rd_req_i(rd_req), .rd_byte_o(rd_byte_o),
    .irq_n_o(irq_n_o), .key_event_i(key_event), .pwm_end_i(pwm_end),
    .fifo_flush_o(fifo_flush_o), .cfg_o(cfg_o), .active_time_o(active_time_o),
    .debounce_o(debounce_o), .key_size_o(key_size_o), .clk_cfg_o(clk_cfg_o),
    .gpio_pull_o(gpio_pull_o), .gpio_dir_o(gpio_dir_o), .gpio_state_o(gpio_state_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_cfg, m_status, m_err, m_act, m_deb, m_size, m_clk, m_pull, m_dir, m_state;
  int m_cmd, m_cnt, m_rd, m_flush;
  bit m_srst;

  task automatic m_defaults();
    m_cfg = 'h80; m_status = 'h10; m_act = 125; m_deb = 3; m_size = 'h33; m_clk = 'h08;
    m_pull = 0; m_dir = 0; m_state = 0; m_err = 0;
  endtask

  task automatic m_raise(input int bits);
    m_err    = m_err | bits;
    m_status = m_status | 'h08;
  endtask

  function automatic int put16(input int old, input int idx, input int b);
    if (idx == 0) return b;
    return (old & 'hFF) | (b << 8);
  endfunction

  task automatic m_param(input int b, input int idx);
    int lo, hi;
    if (m_cmd < 0) begin m_raise(1); return; end
    case (m_cmd)
      'h81: begin m_cfg = b; m_status = 0; m_flush = 1; m_cmd = -1; end
      'h83: begin
        if (b == 'hAA) begin m_defaults(); m_srst = 1; end
        else m_raise(1);
        m_cmd = -1;
      end
      'h84: begin m_pull  = put16(m_pull, idx, b);  if (idx == 1) m_cmd = -1; end
      'h85: begin m_dir   = put16(m_dir, idx, b);   if (idx == 1) m_cmd = -1; end
      'h86: begin m_state = put16(m_state, idx, b); if (idx == 1) m_cmd = -1; end
      'h8B: begin m_act = b; m_cmd = -1; end
      'h8F: begin m_deb = b; m_cmd = -1; if (b == 0) m_raise(1); end
      'h90: begin
        m_size = b; m_cmd = -1;
        lo = b % 16; hi = b / 16;
        if (lo < 3 || lo > 12 || hi < 3 || hi > 8) m_raise(1);
      end
      'h93: begin m_clk = b; m_cmd = -1; if ((b % 4) == 1 || (b % 4) == 2) m_raise(1); end
      default: m_raise(2);
    endcase
  endtask

  function automatic int byte_of(input int v, input int idx);
    if (idx == 0) return v & 'hFF;
    if (idx == 1) return (v >> 8) & 'hFF;
    return 0;
  endfunction

  task automatic m_read(input int idx);
    case (m_cmd)
      'h80: m_rd = byte_of('h0400, idx);
      'h82: begin m_rd = m_status; if ((m_status & 'h10) == 0) m_status = 0; end
      'h87: m_rd = byte_of(m_dir, idx);
      'h88: m_rd = byte_of(m_state, idx);
      'h8C: m_rd = m_err;
      'h91: m_rd = m_size;
      'h92: m_rd = m_cfg & 'h0F;
      'h94: m_rd = (m_clk & 'hFC) | 2;
      default: begin m_rd = 0; m_raise(2); end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_defaults(); m_cmd = -1; m_cnt = 0; m_rd = 0; m_flush = 0;
    end else begin
      m_flush = 0; m_srst = 0;
      if (txn_start) m_cnt = 0;
      else if (wr_valid) begin
        if (m_cnt == 0) m_cmd = wr_byte;
        else m_param(wr_byte, m_cnt - 1);
        m_cnt++;
      end else if (rd_req) begin
        m_read(m_cnt);
        m_cnt++;
      end
      if (!m_srst) begin
        if (key_event) m_status = m_status | 1;
        m_status = m_status | (int'(pwm_end) << 5);
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      cmp("R2 irq_n", int'(irq_n_o), (m_status == 0) ? 1 : 0);
      cmp("R14 rd_byte", int'(rd_byte_o), m_rd);
      cmp("R5 flush", int'(fifo_flush_o), m_flush);
      cmp("R5 cfg", int'(cfg_o), m_cfg);
      cmp("R8 active", int'(active_time_o), m_act);
      cmp("R8 debounce", int'(debounce_o), m_deb);
      cmp("R7 size", int'(key_size_o), m_size);
      cmp("R9 clock", int'(clk_cfg_o), m_clk);
      cmp("R6 pull", int'(gpio_pull_o), m_pull);
      cmp("R6 dir", int'(gpio_dir_o), m_dir);
      cmp("R6 state", int'(gpio_state_o), m_state);
    end
  end

  // ---------------- stimulus ----------------
  task automatic clear_in();
    txn_start = 0; txn_write = 0; wr_valid = 0; rd_req = 0; key_event = 0; pwm_end = 0;
  endtask

  task automatic idle();
    @(negedge clk); clear_in();
  endtask

  task automatic do_start(input bit wr);
    @(negedge clk); clear_in(); txn_start = 1; txn_write = wr;
  endtask

  task automatic do_wr(input logic [7:0] b);
    @(negedge clk); clear_in(); wr_valid = 1; wr_byte = b;
  endtask

  task automatic settle();
    @(posedge clk); #3;
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string tag);
    @(negedge clk); clear_in(); rd_req = 1;
    settle();
    cmp(tag, int'(rd_byte_o), int'(exp));
  endtask

  task automatic cmd(input logic [7:0] c);
    do_start(1); do_wr(c);
  endtask

  task automatic cmd1(input logic [7:0] c, input logic [7:0] p);
    do_start(1); do_wr(c); do_wr(p);
  endtask

  task automatic rd_txn(input logic [7:0] c);
    cmd(c); do_start(0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200_000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    // R1 reset state
    cmp("R1 cfg", int'(cfg_o), 'h80);
    cmp("R1 active", int'(active_time_o), 125);
    cmp("R1 debounce", int'(debounce_o), 3);
    cmp("R1 size", int'(key_size_o), 'h33);
    cmp("R1 clock", int'(clk_cfg_o), 'h08);
    cmp("R1 irq_n", int'(irq_n_o), 0);

    // R3 not-initialised blocks the clear
    rd_txn(8'h82);
    rd_chk(8'h10, "R3 status noinit");
    rd_chk(8'h10, "R3 status held");

    // R5 configuration write
    cmd(8'h81); do_wr(8'h5A);
    settle();
    cmp("R5 flush pulse", int'(fifo_flush_o), 1);
    cmp("R5 status cleared irq_n", int'(irq_n_o), 1);
    rd_txn(8'h92);
    rd_chk(8'h0A, "R5 cfg low nibble");

    // R13 parameter with idle latch, R12 error and irq
    cmd1(8'h8B, 8'h40);
    do_wr(8'h00);
    settle();
    cmp("R13 badpar irq_n", int'(irq_n_o), 0);
    rd_txn(8'h8C);
    rd_chk(8'h01, "R12 error byte");
    rd_txn(8'h82);
    rd_chk(8'h08, "R12 status error bit");
    rd_chk(8'h00, "R3 status cleared");
    cmp("R3 irq released", int'(irq_n_o), 1);

    // R6 GPIO 16-bit
    cmd(8'h85); do_wr(8'h34); do_wr(8'h12);
    settle();
    cmp("R6 dir", int'(gpio_dir_o), 'h1234);
    rd_txn(8'h87);
    rd_chk(8'h34, "R6 dir low");
    rd_chk(8'h12, "R6 dir high");
    rd_chk(8'h00, "R6 dir beyond");
    cmd(8'h84); do_wr(8'h77);
    settle();
    cmp("R6 pull zero-extend", int'(gpio_pull_o), 'h0077);
    do_wr(8'h88);
    settle();
    cmp("R6 pull high", int'(gpio_pull_o), 'h8877);
    cmd(8'h86); do_wr(8'hC3); do_wr(8'h5E);
    rd_txn(8'h88);
    rd_chk(8'hC3, "R6 state low");

    // R7 key size
    cmd1(8'h90, 8'h48);
    settle();
    cmp("R7 good size irq_n", int'(irq_n_o), 1);
    cmd1(8'h90, 8'h94);
    settle();
    cmp("R7 cols 9 bad irq_n", int'(irq_n_o), 0);
    rd_txn(8'h91);
    rd_chk(8'h94, "R7 size stored");
    rd_txn(8'h82); rd_chk(8'h08, "R7 status err");
    cmd1(8'h90, 8'h3D);
    settle();
    cmp("R7 rows 13 bad irq_n", int'(irq_n_o), 0);
    rd_txn(8'h82); rd_chk(8'h08, "R7 status err 2");

    // R8 debounce and active
    cmd1(8'h8F, 8'h00);
    settle();
    cmp("R8 debounce zero irq_n", int'(irq_n_o), 0);
    rd_txn(8'h82); rd_chk(8'h08, "R8 status err");
    cmd1(8'h8F, 8'h07);
    cmd1(8'h8B, 8'hE1);
    settle();
    cmp("R8 active stored", int'(active_time_o), 'hE1);
    cmp("R8 debounce ok irq_n", int'(irq_n_o), 1);

    // R9 clock
    cmd1(8'h93, 8'h11);
    settle();
    cmp("R9 clock 01 bad irq_n", int'(irq_n_o), 0);
    rd_txn(8'h82); rd_chk(8'h08, "R9 status err");
    cmd1(8'h93, 8'hF3);
    rd_txn(8'h94);
    rd_chk(8'hF2, "R9 clock view");
    cmp("R9 clock 11 ok irq_n", int'(irq_n_o), 1);

    // R10 identification
    rd_txn(8'h80);
    rd_chk(8'h00, "R10 id byte0");
    rd_chk(8'h04, "R10 id byte1");
    rd_chk(8'h00, "R10 id byte2");

    // R13 start restarts the index
    do_start(0);
    rd_chk(8'h00, "R13 restart idx0");
    do_start(0);
    rd_chk(8'h00, "R13 restart idx0 again");

    // R11 unknown command
    cmd1(8'h99, 8'h01);
    rd_txn(8'h8C);
    rd_chk(8'h03, "R11 unknown write");
    cmd1(8'h81, 8'h00);
    do_start(0);
    rd_chk(8'h00, "R11 idle read data");
    settle();
    cmp("R11 idle read irq_n", int'(irq_n_o), 0);
    rd_txn(8'h82); rd_chk(8'h08, "R11 status err");

    // R2 set wins against the status clear
    @(negedge clk); clear_in(); key_event = 1;
    settle();
    cmp("R2 key irq_n", int'(irq_n_o), 0);
    rd_txn(8'h82);
    @(negedge clk); clear_in(); rd_req = 1; key_event = 1;
    settle();
    cmp("R2 read with key data", int'(rd_byte_o), 'h01);
    cmp("R2 set survives clear", int'(irq_n_o), 0);
    @(negedge clk); clear_in(); rd_req = 1; pwm_end = 3'b100;
    settle();
    rd_chk(8'h80, "R2 pwm end bit 7");
    cmp("R2 irq released", int'(irq_n_o), 1);
    cmd(8'h81);
    @(negedge clk); clear_in(); wr_valid = 1; wr_byte = 8'h02; key_event = 1;
    settle();
    cmp("R2 key survives cfg clear", int'(irq_n_o), 0);

    // R4 software reset
    cmd1(8'h83, 8'h55);
    rd_txn(8'h8C);
    rd_chk(8'h03, "R4 bad key errs");
    cmd1(8'h83, 8'hAA);
    settle();
    cmp("R4 cfg restored", int'(cfg_o), 'h80);
    cmp("R4 dir cleared", int'(gpio_dir_o), 0);
    rd_txn(8'h8C);
    rd_chk(8'h00, "R4 errors cleared");
    rd_txn(8'h82);
    rd_chk(8'h10, "R4 status noinit");

    repeat (3) idle();
    finish_run();
  end

endmodule